// File: doc/BRIEF.md
# Video Frame Geometry Checker

This block watches a video pixel stream, as seen on an AXI4-Stream style valid/ready handshake, and compares what arrives against a programmed geometry. The geometry is a line width in bytes and a frame height in lines. A start-of-frame marker rides on the user bit and an end-of-line marker rides on the last flag. Each accepted beat adds the number of its set keep bits to the running byte count of the current line, so a line may end on a partial beat.

Four kinds of mismatch are tracked separately. A line can end short or run long, and a frame can restart before all its lines are in or collect too many lines. Each mismatch raises its own sticky flag, which software clears by writing a one. A mask can hide any flag from the single interrupt request. Frame-level mismatches also raise a recoverable internal-error status. A start command carrying a zero width or a zero height is a fatal configuration error: it stops the checker, and only a reset clears it. None of the four mismatches stops the checker.

Top module: `vid_geom_check`

## Requirements
- R1: After reset, all four error flags, the internal-error output, the run output and the interrupt request are 0.
- R2: A start pulse with non-zero width and height sets run in the next cycle and arms the checker. Accepted beats (valid, ready and run all high) are not checked until the first beat that carries the user bit.
- R3: The byte count of a beat is the number of set keep bits. A beat with last set that closes a line of fewer than the programmed width sets flag bit 1 (line ended early).
- R4: Flag bit 3 (line too long) is set when a beat without last brings the line to at least the width. It is also set when a beat with last brings the line above the width.
- R5: Flag bit 0 (frame restarted early) is set by a user-bit beat that arrives inside a frame while fewer than the programmed height of lines are complete. That beat begins a new frame.
- R6: Flag bit 2 (frame too long) is set when a line completes while the programmed height of lines is already complete in the current frame.
- R7: The flags are sticky. A 1 in err_clr bit n (n = 0..3) clears flag bit n in the next cycle. A set in the same cycle wins over the clear. No flag changes run.
- R8: irq is high exactly when some flag bit is 1 and the err_mask bit at the same position is 0.
- R9: Setting flag bit 0 or bit 2 also sets int_err. Writing 1 to err_clr bit 4 clears that recoverable part in the next cycle.
- R10: A start pulse with zero width or zero height sets a fatal state. That state drives int_err to 1 and run to 0 from the next cycle. err_clr cannot clear it and later starts are ignored; only reset clears it.
- R11: Width and height are captured on an accepted start. Later changes on cfg_hsize and cfg_vsize have no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start strobe; captures the geometry |
| cfg_hsize | input | 16 | Line width in bytes |
| cfg_vsize | input | 13 | Frame height in lines |
| err_mask | input | 4 | Interrupt mask, 1 hides the flag at the same position |
| err_clr | input | 5 | Write-one-to-clear: bits 3..0 clear the flags, bit 4 clears the recoverable internal error |
| s_valid | input | 1 | Stream valid |
| s_ready | input | 1 | Stream ready, as driven by the consumer |
| s_user | input | 1 | Start-of-frame marker |
| s_last | input | 1 | End-of-line marker |
| s_keep | input | KEEP_W | Byte enables of the beat |
| err_flags | output | 4 | Sticky flags: 0 frame early, 1 line early, 2 frame long, 3 line long |
| int_err | output | 1 | Internal error (fatal or frame mismatch) |
| run | output | 1 | Checker armed |
| irq | output | 1 | Masked error interrupt request |

## Verification
The properties assume that start never coincides with an accepted beat. They also assume that a beat offered with ready low is held until it is taken, so the flags change only through handshakes or clears. The stimulus drives all inputs on the falling edge and issues start only between beats. It generates frames whose line lengths and line counts stray by a few units around the programmed geometry, sometimes drops an end-of-line marker, and inserts ready stalls, random clears and mask changes. Directed cases cover partial beats, a set and a clear in the same cycle, the geometry inputs changing after start, and a zero-size start.

// File: rtl/vgc_pkg.sv
// Shared constants for the video frame geometry checker.
// Assumes: flag bit positions are fixed and visible to software.
package vgc_pkg;
    localparam int FLAG_W       = 4;
    localparam int HSIZE_W      = 16;
    localparam int VSIZE_W      = 13;
    localparam int B_SOF_EARLY  = 0;
    localparam int B_EOL_EARLY  = 1;
    localparam int B_SOF_LATE   = 2;
    localparam int B_EOL_LATE   = 3;
    typedef logic [FLAG_W-1:0] flag_vec_t;
endpackage

// File: rtl/vgc_keep_count.sv
// Counts the set byte enables of one beat.
// Assumes: any keep pattern is legal; the count is purely combinational.
module vgc_keep_count #(
    parameter int KEEP_W = 4,
    localparam int CNT_W = $clog2(KEEP_W + 1)
) (
    input  logic [KEEP_W-1:0] keep,
    output logic [CNT_W-1:0]  nbytes
);
    logic [CNT_W-1:0] psum [0:KEEP_W];

    // Ripple of partial sums, one adder per byte lane.
    assign psum[0] = '0;
    for (genvar i = 0; i < KEEP_W; i++) begin : g_lane
        assign psum[i+1] = psum[i] + CNT_W'(keep[i]);
    end
    assign nbytes = psum[KEEP_W];
endmodule

// File: rtl/vgc_frame_track.sv
// Tracks frame membership and completed lines; detects early and late frame starts.
// Assumes: beat already includes the run qualifier; arm clears the tracking state.
module vgc_frame_track #(
    parameter int VSIZE_W = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm,
    input  logic               beat,
    input  logic               sof,
    input  logic               last,
    input  logic [VSIZE_W-1:0] vsize,
    output logic               track,
    output logic               sof_early,
    output logic               sof_late
);
    logic               in_frame_q;
    logic [VSIZE_W-1:0] lcnt_q;
    logic [VSIZE_W-1:0] base_l;
    logic               full;

    // Line count seen by this beat: a frame start restarts it.
    always_comb begin
        base_l    = sof ? '0 : lcnt_q;
        full      = (base_l >= vsize);
        track     = beat & (in_frame_q | sof);
        sof_early = beat & sof & in_frame_q & (lcnt_q < vsize);
        sof_late  = track & last & full;
    end

    // Frame membership and completed-line counter.
    always_ff @(posedge clk) begin
        if (!rst_n || arm) begin
            in_frame_q <= 1'b0;
            lcnt_q     <= '0;
        end else if (track) begin
            in_frame_q <= 1'b1;
            lcnt_q     <= (last && !full) ? base_l + 1'b1 : base_l;
        end
    end
endmodule

// File: rtl/vgc_line_track.sv
// Accumulates bytes of the current line and detects short and long lines.
// Assumes: track is high only for accepted beats inside a frame.
module vgc_line_track #(
    parameter int HSIZE_W = 16,
    parameter int CNT_W   = 3,
    localparam int BC_W   = HSIZE_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm,
    input  logic               track,
    input  logic               sof,
    input  logic               last,
    input  logic [CNT_W-1:0]   nbytes,
    input  logic [HSIZE_W-1:0] hsize,
    output logic               eol_early,
    output logic               eol_late
);
    logic [BC_W-1:0] bcnt_q;
    logic [BC_W-1:0] base_b;
    logic [BC_W:0]   sum_full;
    logic [BC_W-1:0] sum_sat;
    logic [BC_W-1:0] hs;

    // Byte total including this beat, saturated to the counter width.
    always_comb begin
        base_b    = sof ? '0 : bcnt_q;
        sum_full  = {1'b0, base_b} + {{(BC_W + 1 - CNT_W){1'b0}}, nbytes};
        sum_sat   = sum_full[BC_W] ? '1 : sum_full[BC_W-1:0];
        hs        = {1'b0, hsize};
        eol_early = track & last & (sum_sat < hs);
        eol_late  = track & (last ? (sum_sat > hs) : (sum_sat >= hs));
    end

    // Running byte count of the open line.
    always_ff @(posedge clk) begin
        if (!rst_n || arm) begin
            bcnt_q <= '0;
        end else if (track) begin
            bcnt_q <= last ? '0 : sum_sat;
        end
    end
endmodule

// File: rtl/vgc_err_regs.sv
// Sticky error flags with write-one-to-clear, masking and the recoverable internal error.
// Assumes: a set and a clear in the same cycle resolve in favour of the set.
module vgc_err_regs
    import vgc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  flag_vec_t       set,
    input  logic [4:0]      clr,
    input  flag_vec_t       mask,
    output flag_vec_t       flags,
    output logic            size_err,
    output logic            irq
);
    flag_vec_t flags_q;
    logic      size_q;

    // Flag and recoverable-error state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            size_q  <= 1'b0;
        end else begin
            flags_q <= (flags_q & ~clr[FLAG_W-1:0]) | set;
            size_q  <= (size_q & ~clr[4]) | set[B_SOF_EARLY] | set[B_SOF_LATE];
        end
    end

    assign flags    = flags_q;
    assign size_err = size_q;
    assign irq      = |(flags_q & ~mask);
endmodule

// File: rtl/vid_geom_check.sv
// Video frame geometry checker top: captures geometry on start, qualifies beats,
// and collects line and frame mismatches into sticky flags and an interrupt.
// Assumes: start does not coincide with an accepted beat; reset is synchronous.
module vid_geom_check
    import vgc_pkg::*;
#(
    parameter int KEEP_W = 4,
    localparam int CNT_W = $clog2(KEEP_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [HSIZE_W-1:0] cfg_hsize,
    input  logic [VSIZE_W-1:0] cfg_vsize,
    input  logic [FLAG_W-1:0]  err_mask,
    input  logic [4:0]         err_clr,
    input  logic               s_valid,
    input  logic               s_ready,
    input  logic               s_user,
    input  logic               s_last,
    input  logic [KEEP_W-1:0]  s_keep,
    output logic [FLAG_W-1:0]  err_flags,
    output logic               int_err,
    output logic               run,
    output logic               irq
);
    logic [HSIZE_W-1:0] hsize_q;
    logic [VSIZE_W-1:0] vsize_q;
    logic               run_q;
    logic               fatal_q;
    logic               zero_cfg, go, arm, beat, track;
    logic               sof_early, sof_late, eol_early, eol_late, size_err;
    logic [CNT_W-1:0]   nbytes;
    flag_vec_t          set_vec;

    // Start decode and beat qualification.
    always_comb begin
        zero_cfg = (cfg_hsize == '0) || (cfg_vsize == '0);
        go       = start & ~fatal_q;
        arm      = go & ~zero_cfg;
        beat     = s_valid & s_ready & run_q;
    end

    // Geometry capture, run state and the fatal configuration error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsize_q <= '0;
            vsize_q <= '0;
            run_q   <= 1'b0;
            fatal_q <= 1'b0;
        end else if (go) begin
            if (zero_cfg) begin
                fatal_q <= 1'b1;
                run_q   <= 1'b0;
            end else begin
                hsize_q <= cfg_hsize;
                vsize_q <= cfg_vsize;
                run_q   <= 1'b1;
            end
        end
    end

    vgc_keep_count #(.KEEP_W(KEEP_W)) u_keep (
        .keep   (s_keep),
        .nbytes (nbytes)
    );

    vgc_frame_track #(.VSIZE_W(VSIZE_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .beat      (beat),
        .sof       (s_user),
        .last      (s_last),
        .vsize     (vsize_q),
        .track     (track),
        .sof_early (sof_early),
        .sof_late  (sof_late)
    );

    vgc_line_track #(.HSIZE_W(HSIZE_W), .CNT_W(CNT_W)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .track     (track),
        .sof       (s_user),
        .last      (s_last),
        .nbytes    (nbytes),
        .hsize     (hsize_q),
        .eol_early (eol_early),
        .eol_late  (eol_late)
    );

    // Gather the four detections into their flag positions.
    always_comb begin
        set_vec              = '0;
        set_vec[B_SOF_EARLY] = sof_early;
        set_vec[B_EOL_EARLY] = eol_early;
        set_vec[B_SOF_LATE]  = sof_late;
        set_vec[B_EOL_LATE]  = eol_late;
    end

    vgc_err_regs u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (set_vec),
        .clr      (err_clr),
        .mask     (err_mask),
        .flags    (err_flags),
        .size_err (size_err),
        .irq      (irq)
    );

    assign run     = run_q;
    assign int_err = fatal_q | size_err;
endmodule

// File: rtl/vid_geom_check_sva.sv
// Property checker for the geometry checker, attached through bind.
// Assumes: observes only the top-level ports.
module vid_geom_check_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [15:0] cfg_hsize,
    input logic [12:0] cfg_vsize,
    input logic [4:0]  err_clr,
    input logic        s_valid,
    input logic        s_ready,
    input logic        s_last,
    input logic [3:0]  err_flags,
    input logic        int_err,
    input logic        run,
    input logic        irq
);
    // R10: a zero-size start leaves the checker stopped with the internal error raised.
    p_zero_start_fatal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (cfg_hsize == 16'd0 || cfg_vsize == 13'd0)) |=> (!run && int_err));

    // R7: a flag that is set and not being cleared stays set.
    p_flags_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((err_flags & $past(err_flags & ~err_clr[3:0])) == $past(err_flags & ~err_clr[3:0])));

    // R8: the interrupt needs at least one raised flag.
    p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (err_flags != 4'd0));

    // R2: with the checker stopped and no clear, the flags hold.
    p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && err_clr == 5'd0) |=> $stable(err_flags));

    // R9: an early frame start also raises the internal error.
    p_sof_early_int_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flags[0]) |-> int_err);

    // R3: a short line is only reported after an accepted end-of-line beat.
    p_eol_early_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flags[1]) |-> $past(s_valid && s_ready && s_last && run));
endmodule

bind vid_geom_check vid_geom_check_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cfg_hsize (cfg_hsize),
    .cfg_vsize (cfg_vsize),
    .err_clr   (err_clr),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .s_last    (s_last),
    .err_flags (err_flags),
    .int_err   (int_err),
    .run       (run),
    .irq       (irq)
);

// File: tb/sim_vid_geom_check.sv
module sim_vid_geom_check;
    localparam int KW = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n, start;
    logic [15:0]   cfg_hsize;
    logic [12:0]   cfg_vsize;
    logic [3:0]    err_mask;
    logic [4:0]    err_clr;
    logic          s_valid, s_ready, s_user, s_last;
    logic [KW-1:0] s_keep;
    logic [3:0]    err_flags;
    logic          int_err, run, irq;

    vid_geom_check #(.KEEP_W(KW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_hsize(cfg_hsize),
        .cfg_vsize(cfg_vsize), .err_mask(err_mask), .err_clr(err_clr),
        .s_valid(s_valid), .s_ready(s_ready), .s_user(s_user), .s_last(s_last),
        .s_keep(s_keep), .err_flags(err_flags), .int_err(int_err), .run(run), .irq(irq)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Requirement model state
    logic [3:0] m_err;
    logic       m_size, m_fatal, m_run, m_inf;
    int         m_h, m_v, m_b, m_l;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] model_out();
        return {m_err, m_size | m_fatal, m_run, |(m_err & ~err_mask)};
    endfunction

    task automatic cmp_model(input string tag);
        logic [6:0] act;
        act = {err_flags, int_err, run, irq};
        chk(act == model_out(), tag, 32'(act), 32'(model_out()));
    endtask

    task automatic do_reset();
        rst_n = 1'b0; start = 1'b0; cfg_hsize = '0; cfg_vsize = '0;
        err_mask = '0; err_clr = '0; s_valid = 1'b0; s_ready = 1'b0;
        s_user = 1'b0; s_last = 1'b0; s_keep = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_err = '0; m_size = 1'b0; m_fatal = 1'b0; m_run = 1'b0; m_inf = 1'b0;
        m_h = 0; m_v = 0; m_b = 0; m_l = 0;
        @(negedge clk);
    endtask

    task automatic do_start(input int h, input int v);
        cfg_hsize = 16'(h); cfg_vsize = 13'(v); start = 1'b1;
        if (!m_fatal) begin
            if (h == 0 || v == 0) begin
                m_fatal = 1'b1; m_run = 1'b0;
            end else begin
                m_run = 1'b1; m_h = h; m_v = v; m_inf = 1'b0; m_b = 0; m_l = 0;
            end
        end
        @(negedge clk);
        start = 1'b0;
        cmp_model("R2 R10 R11 start");
    endtask

    task automatic idle(input logic [4:0] clr);
        err_clr = clr;
        m_err  = m_err & ~clr[3:0];
        m_size = m_size & ~clr[4];
        @(negedge clk);
        err_clr = '0;
        cmp_model("R7 R9 clear");
    endtask

    task automatic send(input bit u, input bit l, input logic [KW-1:0] k,
                        input bit rdy, input logic [4:0] clr);
        logic [3:0] set;
        int n, nb;
        set = '0;
        s_valid = 1'b1; s_ready = rdy; s_user = u; s_last = l; s_keep = k; err_clr = clr;
        if (m_run && rdy) begin
            n = $countones(k);
            if (u) begin
                if (m_inf && m_l < m_v) set[0] = 1'b1;
                m_inf = 1'b1; m_b = 0; m_l = 0;
            end
            if (m_inf) begin
                nb = m_b + n;
                if (l) begin
                    if (nb < m_h) set[1] = 1'b1;
                    if (nb > m_h) set[3] = 1'b1;
                    m_b = 0;
                    if (m_l >= m_v) set[2] = 1'b1;
                    else m_l++;
                end else begin
                    if (nb >= m_h) set[3] = 1'b1;
                    m_b = (nb > 131071) ? 131071 : nb;
                end
            end
        end
        m_err  = (m_err & ~clr[3:0]) | set;
        m_size = (m_size & ~clr[4]) | set[0] | set[2];
        @(negedge clk);
        s_valid = 1'b0; s_ready = 1'b0; s_user = 1'b0; s_last = 1'b0; s_keep = '0; err_clr = '0;
        cmp_model("R3 R4 R5 R6 R8 R9 beat");
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        do_reset();
        chk({err_flags, int_err, run, irq} == 7'd0, "R1 reset state", 32'({err_flags, int_err, run, irq}), 0);

        do_start(8, 2);
        chk(run == 1'b1, "R2 run after start", 32'(run), 1);
        send(1'b0, 1'b1, 4'b0011, 1'b1, 5'd0);
        chk(err_flags == 4'd0, "R2 beat before frame start ignored", 32'(err_flags), 0);

        send(1'b1, 1'b0, 4'b1111, 1'b1, 5'd0);
        send(1'b0, 1'b1, 4'b0011, 1'b1, 5'd0);
        chk(err_flags == 4'b0010, "R3 short line 6 of 8", 32'(err_flags), 32'h2);
        chk(irq == 1'b1, "R8 unmasked irq", 32'(irq), 1);
        err_mask = 4'b0010;
        #1;
        chk(irq == 1'b0, "R8 masked irq", 32'(irq), 0);
        err_mask = 4'b0000;
        @(negedge clk);

        idle(5'b00010);
        chk(err_flags == 4'd0 && run == 1'b1, "R7 write one clears, run kept",
            32'({err_flags, run}), 32'h1);

        send(1'b0, 1'b0, 4'b1111, 1'b1, 5'd0);
        send(1'b0, 1'b0, 4'b1111, 1'b1, 5'd0);
        chk(err_flags == 4'b1000, "R4 line reached width without last", 32'(err_flags), 32'h8);
        send(1'b0, 1'b1, 4'b0001, 1'b1, 5'd0);

        send(1'b0, 1'b1, 4'b1111, 1'b1, 5'd0);
        chk(err_flags[2] == 1'b1, "R6 third line of two", 32'(err_flags), 32'hE);
        chk(int_err == 1'b1, "R9 frame mismatch raises internal error", 32'(int_err), 1);
        idle(5'b10000);
        chk(int_err == 1'b0 && err_flags == 4'b1110, "R9 bit 4 clears internal error",
            32'({err_flags, int_err}), 32'h1C);
        idle(5'b01111);

        send(1'b1, 1'b0, 4'b1111, 1'b1, 5'd0);
        send(1'b0, 1'b1, 4'b1111, 1'b1, 5'd0);
        send(1'b1, 1'b0, 4'b1111, 1'b1, 5'd0);
        chk(err_flags == 4'b0001, "R5 frame restart after one of two lines", 32'(err_flags), 32'h1);
        chk(int_err == 1'b1, "R9 early frame start raises internal error", 32'(int_err), 1);

        cfg_hsize = 16'd2;
        cfg_vsize = 13'd1;
        send(1'b0, 1'b1, 4'b1111, 1'b1, 5'd0);
        chk(err_flags[1] == 1'b0 && err_flags[3] == 1'b0, "R11 captured width still 8",
            32'(err_flags), 32'h1);
        send(1'b1, 1'b1, 4'b0001, 1'b1, 5'b00010);
        chk(err_flags[1] == 1'b1, "R7 set wins over clear", 32'(err_flags[1]), 1);
        send(1'b0, 1'b1, 4'b0001, 1'b0, 5'd0);
        chk(err_flags == 4'b0011, "R7 stalled beat changes nothing", 32'(err_flags), 32'h3);
        idle(5'b11111);

        // Constrained random frames around the programmed geometry
        for (int st = 0; st < 5; st++) begin
            int h, v;
            h = 1 + int'($urandom % 12);
            v = 1 + int'($urandom % 4);
            do_start(h, v);
            for (int fr = 0; fr < 30; fr++) begin
                int nl;
                bit first;
                err_mask = 4'($urandom);
                nl = v + int'($urandom % 3) - 1;
                if (nl < 1) nl = 1;
                first = 1'b1;
                for (int ln = 0; ln < nl; ln++) begin
                    int rem;
                    rem = h + int'($urandom % 5) - 2;
                    if (rem < 1) rem = 1;
                    while (rem > 0) begin
                        int n;
                        bit lst;
                        logic [4:0] clr;
                        logic [KW-1:0] k;
                        n = 1 + int'($urandom % KW);
                        if (n > rem) n = rem;
                        k = KW'((1 << n) - 1);
                        lst = (rem == n) && ($urandom % 8 != 0);
                        clr = ($urandom % 6 == 0) ? 5'($urandom) : 5'd0;
                        if ($urandom % 5 == 0) send(first, lst, k, 1'b0, 5'd0);
                        send(first, lst, k, 1'b1, clr);
                        if ($urandom % 4 == 0) idle(5'd0);
                        first = 1'b0;
                        rem -= n;
                    end
                end
            end
            idle(5'b11111);
        end
        err_mask = 4'd0;
        @(negedge clk);

        do_start(0, 4);
        chk(int_err == 1'b1 && run == 1'b0, "R10 zero width is fatal", 32'({int_err, run}), 32'h2);
        idle(5'b11111);
        chk(int_err == 1'b1, "R10 clear cannot remove fatal", 32'(int_err), 1);
        do_start(8, 2);
        chk(run == 1'b0, "R10 later start ignored", 32'(run), 0);
        send(1'b1, 1'b1, 4'b0001, 1'b1, 5'd0);
        chk(err_flags == 4'd0, "R10 beats unchecked while stopped", 32'(err_flags), 0);

        do_reset();
        chk({err_flags, int_err, run, irq} == 7'd0, "R1 reset clears fatal", 32'({err_flags, int_err, run, irq}), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule